// File: doc/BRIEF.md
# Phase-Locked Up/Down PWM Channel

This block is one channel of a carrier-based PWM generator. A time-base counter sweeps up from zero to a programmed period and back down again, so one carrier cycle takes twice the period in clock ticks. Two compare values are kept in shadow registers and copied into the active set at the turning points of the carrier. Each of the two outputs is pulled low when the counter meets its compare value on the way up, and driven high when it meets it on the way down. The result is a centre-aligned pulse whose width tracks the compare value.

Channels are chained through a one-cycle sync pulse. A channel can emit the pulse whenever its counter sits at zero, or it can forward the pulse it receives. A receiving channel with phase loading enabled jumps to its phase value and takes the count direction stored beside it. A master and a row of followers with phase values of zero, half the period, the full period, and half the period counting the other way therefore give outputs spaced a quarter cycle apart. A shared run input starts or freezes every counter in the same cycle.

A latched trip holds both outputs low from reset until software releases it. Software can also write the counter directly before starting. That write seeds the output levels, so the first carrier cycle after start is already correct.

Top module: `pwm_phase_chan`

## Requirements
- R1: While run is high and nothing else acts on the counter, each tick steps the counter by one. It turns downward at or above the period and upward at zero. A period of 0 holds the counter at 0.
- R2: While run is low the counter, the output levels and the sync output do not change. The sync output stays low.
- R3: Control bit 2 picks the sync source. When clear, sync_out is high during a running tick whose count is 0. When set, sync_out mirrors sync_in during running ticks.
- R4: With control bit 0 set, a running tick with sync_in high loads the counter with the smaller of the phase and the period. The direction becomes control bit 1 (1 = up, 0 = down). With control bit 0 clear, sync_in leaves the count sequence untouched.
- R5: A phase load overrides the reversal that would otherwise happen on a tick at zero or at the period.
- R6: On a running tick where the count equals an active compare value, the matching output goes low on the next tick if counting up, or high if counting down. Output A uses compare A and output B uses compare B.
- R7: An active compare value of 0, or of the period or above, never changes the output.
- R8: A compare write lands in a shadow register. While running, the shadow is copied to the active value only on a tick whose count is 0 or the period. While stopped, it is copied on every tick.
- R9: A counter write has priority over run and sync. It sets the count and takes control bit 1 as the direction. It presets each output level to count <= compare when that bit is 1, or count < compare when it is 0.
- R10: For 0 < compare < period, starting from a counter written to 0 with the up direction, each output is high for exactly 2*compare of every 2*period ticks. Otherwise the output stays high.
- R11: The trip latch is set by reset and by trip_force, and is cleared by trip_clear; force wins if both are high. Outputs are low on every tick after the latch is set.
- R12: Write addresses: 0 period, 1 phase, 2 counter, 3 compare A shadow, 4 compare B shadow, 5 control (bits 2..0 of wr_data).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | CNT_W | Write value |
| run | input | 1 | Time-base enable, shared by all channels |
| trip_force | input | 1 | Set the output trip latch |
| trip_clear | input | 1 | Release the output trip latch |
| sync_in | input | 1 | Sync pulse from the previous channel |
| sync_out | output | 1 | Sync pulse to the next channel |
| cnt_out | output | CNT_W | Present counter value |
| out_a | output | 1 | PWM output A |
| out_b | output | 1 | PWM output B |

## Verification
A wrong direction flag shows on cnt_out on the first tick after a turning point or a phase load. A wrong clamp or a wrong load priority changes the count on the very next tick. A stale active compare, or a mistimed shadow copy, moves an output edge. That only appears when the counter next passes the compare value, up to one carrier cycle later. A wrong preset level shows on the outputs straight after the trip is released. Sweeping small periods against every compare value reaches each of these within a few carrier cycles.

// File: rtl/pwm_phase_pkg.sv
`timescale 1ns/1ps
package pwm_phase_pkg;
   localparam int unsigned ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      RA_PERIOD = 3'd0,
      RA_PHASE  = 3'd1,
      RA_COUNT  = 3'd2,
      RA_CMP_A  = 3'd3,
      RA_CMP_B  = 3'd4,
      RA_CTRL   = 3'd5
   } reg_addr_e;

   // control word, bit 0 = phase load enable, bit 1 = direction after load, bit 2 = sync pass-through
   typedef struct packed {
      logic sync_pass;
      logic phase_up;
      logic phase_en;
   } chan_ctrl_t;

   localparam int unsigned CTRL_W = $bits(chan_ctrl_t);
endpackage

// File: rtl/pwm_regfile.sv
`timescale 1ns/1ps
module pwm_regfile
   import pwm_phase_pkg::*;
#(
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned NUM_CMP = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [CNT_W-1:0]   wr_data,
   output logic [CNT_W-1:0]   period,
   output logic [CNT_W-1:0]   phase,
   output chan_ctrl_t         ctrl,
   output logic               cnt_wr,
   output logic [NUM_CMP-1:0] cmp_wr
);
   localparam int unsigned CMP_BASE = int'(RA_CMP_A);

   initial begin
      if (CNT_W < CTRL_W) $fatal(1, "pwm_regfile: CNT_W narrower than control word");
      if (CMP_BASE + NUM_CMP > (1 << ADDR_W)) $fatal(1, "pwm_regfile: compare slots exceed address space");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         period <= '0;
         phase  <= '0;
         ctrl   <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            RA_PERIOD: period <= wr_data;
            RA_PHASE:  phase  <= wr_data;
            RA_CTRL:   ctrl   <= chan_ctrl_t'(wr_data[CTRL_W-1:0]);
            default:   ;
         endcase
      end
   end

   assign cnt_wr = wr_en && (wr_addr == RA_COUNT);

   generate
      for (genvar gi = 0; gi < NUM_CMP; gi++) begin : g_cmp_dec
         assign cmp_wr[gi] = wr_en && (wr_addr == ADDR_W'(CMP_BASE + gi));
      end
   endgenerate
endmodule

// File: rtl/pwm_timebase.sv
`timescale 1ns/1ps
module pwm_timebase
   import pwm_phase_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] period,
   input  logic [CNT_W-1:0] phase,
   input  chan_ctrl_t       ctrl,
   input  logic             sync_in,
   input  logic             cnt_wr,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] cnt,
   output logic             step_up,
   output logic             at_zero,
   output logic             at_period,
   output logic             sync_out
);
   logic             up_q;
   logic             ph_load;
   logic [CNT_W-1:0] ph_clamp;

   always_comb begin
      at_zero   = (cnt == '0);
      at_period = (cnt == period);
      if (period == '0 || at_zero) step_up = 1'b1;
      else if (cnt >= period)      step_up = 1'b0;
      else                         step_up = up_q;
      ph_clamp = (phase > period) ? period : phase;
      ph_load  = sync_in && ctrl.phase_en;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         up_q <= 1'b1;
      end else if (cnt_wr) begin
         cnt  <= wr_data;
         up_q <= ctrl.phase_up;
      end else if (run) begin
         if (ph_load) begin
            cnt  <= ph_clamp;
            up_q <= ctrl.phase_up;
         end else if (period == '0) begin
            cnt  <= '0;
            up_q <= 1'b1;
         end else begin
            cnt  <= step_up ? cnt + 1'b1 : cnt - 1'b1;
            up_q <= step_up;
         end
      end
   end

   assign sync_out = run && (ctrl.sync_pass ? sync_in : at_zero);
endmodule

// File: rtl/pwm_cmp_action.sv
`timescale 1ns/1ps
module pwm_cmp_action #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] period,
   input  logic             step_up,
   input  logic             at_zero,
   input  logic             at_period,
   input  logic             shadow_wr,
   input  logic             cnt_wr,
   input  logic             preset_up,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] cmp_act,
   output logic             level
);
   logic [CNT_W-1:0] cmp_sh;
   logic             match;
   logic             preset_lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cmp_sh <= '0;
      else if (shadow_wr) cmp_sh <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             cmp_act <= '0;
      else if (!run || at_zero || at_period)  cmp_act <= cmp_sh;
   end

   always_comb begin
      match      = run && (cmp_act != '0) && (cmp_act < period) && (cnt == cmp_act);
      preset_lvl = preset_up ? (wr_data <= cmp_act) : (wr_data < cmp_act);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      level <= 1'b1;
      else if (cnt_wr) level <= preset_lvl;
      else if (match)  level <= !step_up;
   end
endmodule

// File: rtl/pwm_phase_chan.sv
`timescale 1ns/1ps
module pwm_phase_chan
   import pwm_phase_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic              run,
   input  logic              trip_force,
   input  logic              trip_clear,
   input  logic              sync_in,
   output logic              sync_out,
   output logic [CNT_W-1:0]  cnt_out,
   output logic              out_a,
   output logic              out_b
);
   localparam int unsigned NUM_OUT = 2;

   initial begin
      if (CNT_W < 2 || CNT_W > 32) $fatal(1, "pwm_phase_chan: CNT_W out of range");
   end

   logic [CNT_W-1:0]                period_q;
   logic [CNT_W-1:0]                phase_q;
   chan_ctrl_t                      ctrl_q;
   logic                            cnt_wr;
   logic [NUM_OUT-1:0]              cmp_wr;
   logic [NUM_OUT-1:0]              lvl;
   logic [NUM_OUT-1:0][CNT_W-1:0]   cmp_act;
   logic                            step_up;
   logic                            at_zero;
   logic                            at_period;
   logic                            trip_q;

   pwm_regfile #(.CNT_W(CNT_W), .NUM_CMP(NUM_OUT)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .period  (period_q),
      .phase   (phase_q),
      .ctrl    (ctrl_q),
      .cnt_wr  (cnt_wr),
      .cmp_wr  (cmp_wr)
   );

   pwm_timebase #(.CNT_W(CNT_W)) u_tb (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .period    (period_q),
      .phase     (phase_q),
      .ctrl      (ctrl_q),
      .sync_in   (sync_in),
      .cnt_wr    (cnt_wr),
      .wr_data   (wr_data),
      .cnt       (cnt_out),
      .step_up   (step_up),
      .at_zero   (at_zero),
      .at_period (at_period),
      .sync_out  (sync_out)
   );

   generate
      for (genvar gi = 0; gi < NUM_OUT; gi++) begin : g_out
         pwm_cmp_action #(.CNT_W(CNT_W)) u_act (
            .clk       (clk),
            .rst_n     (rst_n),
            .run       (run),
            .cnt       (cnt_out),
            .period    (period_q),
            .step_up   (step_up),
            .at_zero   (at_zero),
            .at_period (at_period),
            .shadow_wr (cmp_wr[gi]),
            .cnt_wr    (cnt_wr),
            .preset_up (ctrl_q.phase_up),
            .wr_data   (wr_data),
            .cmp_act   (cmp_act[gi]),
            .level     (lvl[gi])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          trip_q <= 1'b1;
      else if (trip_force) trip_q <= 1'b1;
      else if (trip_clear) trip_q <= 1'b0;
   end

   assign out_a = lvl[0] & ~trip_q;
   assign out_b = lvl[1] & ~trip_q;
endmodule

// File: rtl/pwm_phase_chan_chk.sv
`timescale 1ns/1ps
module pwm_phase_chan_chk #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run,
   input logic             cnt_wr,
   input logic             sync_in,
   input logic             phase_en,
   input logic             trip_force,
   input logic             trip_clear,
   input logic             sync_out,
   input logic             out_a,
   input logic             out_b,
   input logic [CNT_W-1:0] cnt_out,
   input logic [CNT_W-1:0] period,
   input logic [CNT_W-1:0] phase,
   input logic [CNT_W-1:0] cmp_act_a
);
   a_r1_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !cnt_wr && !(sync_in && phase_en) && period != '0)
      |=> (cnt_out == CNT_W'($past(cnt_out) + 1'b1)) || (cnt_out == CNT_W'($past(cnt_out) - 1'b1)));

   a_r2_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !cnt_wr) |=> $stable(cnt_out));

   a_r3_quiet_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !sync_out);

   a_r4_phase_load: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !cnt_wr && sync_in && phase_en)
      |=> cnt_out == (($past(phase) > $past(period)) ? $past(period) : $past(phase)));

   a_r7_no_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_wr && !trip_force && !trip_clear && (cmp_act_a == '0 || cmp_act_a >= period))
      |=> $stable(out_a));

   a_r8_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (run && cnt_out != '0 && cnt_out != period) |=> $stable(cmp_act_a));

   a_r11_trip_low: assert property (@(posedge clk) disable iff (!rst_n)
      trip_force |=> (!out_a && !out_b));
endmodule

bind pwm_phase_chan pwm_phase_chan_chk #(.CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .run        (run),
   .cnt_wr     (cnt_wr),
   .sync_in    (sync_in),
   .phase_en   (ctrl_q.phase_en),
   .trip_force (trip_force),
   .trip_clear (trip_clear),
   .sync_out   (sync_out),
   .out_a      (out_a),
   .out_b      (out_b),
   .cnt_out    (cnt_out),
   .period     (period_q),
   .phase      (phase_q),
   .cmp_act_a  (cmp_act[0])
);

// File: tb/sim_pwm_phase_chan.sv
`timescale 1ns/1ps
module sim_pwm_phase_chan;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [2:0]   wr_addr = '0;
   logic [W-1:0] wr_data = '0;
   logic         run = 1'b0;
   logic         trip_force = 1'b0;
   logic         trip_clear = 1'b0;
   logic         sync_in = 1'b0;
   logic         sync_out;
   logic [W-1:0] cnt_out;
   logic         out_a;
   logic         out_b;

   int n_cmp = 0;
   int n_fail = 0;

   // reference state, derived from the requirement text
   logic [W-1:0] m_cnt, m_per, m_ph;
   logic         m_up, m_trip;
   logic [2:0]   m_ctrl;
   logic [W-1:0] m_act [2];
   logic [W-1:0] m_sh [2];
   logic [1:0]   m_lvl;

   always #10 clk = ~clk;

   pwm_phase_chan #(.CNT_W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .run(run), .trip_force(trip_force), .trip_clear(trip_clear), .sync_in(sync_in),
      .sync_out(sync_out), .cnt_out(cnt_out), .out_a(out_a), .out_b(out_b)
   );

   task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
      n_cmp++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, got, exp, $time);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
   endtask

   // one clock: drive at falling edge, model the rising edge, compare at next falling edge
   task automatic step(input logic w, input logic [2:0] a, input logic [W-1:0] d,
                       input logic r, input logic tf, input logic tc, input logic si);
      logic su, mz, mp, cw, match, n_up;
      logic [W-1:0] n_cnt;
      logic [W-1:0] n_act [2];
      logic [W-1:0] n_sh [2];
      logic [1:0] n_lvl;
      wr_en = w; wr_addr = a; wr_data = d; run = r;
      trip_force = tf; trip_clear = tc; sync_in = si;
      #1;
      chk(sync_out, r && (m_ctrl[2] ? si : (m_cnt == 0)), "R3 sync_out");
      cw = w && (a == 3'd2);
      mz = (m_cnt == 0);
      mp = (m_cnt == m_per);
      if (m_per == 0 || mz) su = 1'b1;
      else if (m_cnt >= m_per) su = 1'b0;
      else su = m_up;
      for (int i = 0; i < 2; i++) begin
         match = r && (m_act[i] != 0) && (m_act[i] < m_per) && (m_cnt == m_act[i]);
         if (cw) n_lvl[i] = m_ctrl[1] ? (d <= m_act[i]) : (d < m_act[i]);
         else if (match) n_lvl[i] = !su;
         else n_lvl[i] = m_lvl[i];
         n_act[i] = (!r || mz || mp) ? m_sh[i] : m_act[i];
         n_sh[i]  = (w && a == 3'(3 + i)) ? d : m_sh[i];
      end
      n_cnt = m_cnt; n_up = m_up;
      if (cw) begin n_cnt = d; n_up = m_ctrl[1]; end
      else if (r) begin
         if (si && m_ctrl[0]) begin n_cnt = (m_ph > m_per) ? m_per : m_ph; n_up = m_ctrl[1]; end
         else if (m_per == 0) begin n_cnt = 0; n_up = 1'b1; end
         else begin n_cnt = su ? m_cnt + 1'b1 : m_cnt - 1'b1; n_up = su; end
      end
      m_cnt = n_cnt; m_up = n_up; m_lvl = n_lvl;
      for (int i = 0; i < 2; i++) begin m_act[i] = n_act[i]; m_sh[i] = n_sh[i]; end
      if (tf) m_trip = 1'b1; else if (tc) m_trip = 1'b0;
      if (w && a == 3'd0) m_per = d;
      if (w && a == 3'd1) m_ph = d;
      if (w && a == 3'd5) m_ctrl = d[2:0];
      @(negedge clk);
      chk(cnt_out, m_cnt, "R1 count");
      chk(out_a, m_lvl[0] & ~m_trip, "R6 out_a");
      chk(out_b, m_lvl[1] & ~m_trip, "R6 out_b");
   endtask

   // R12 address map: 0 period, 1 phase, 2 counter, 3 cmpA, 4 cmpB, 5 control
   task automatic wr(input logic [2:0] a, input logic [W-1:0] d, input logic r);
      step(1'b1, a, d, r, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic idle(input int n, input logic r);
      for (int k = 0; k < n; k++) step(1'b0, 3'd0, '0, r, 1'b0, 1'b0, 1'b0);
   endtask

   // R10 duty sweep case: high ticks over two carrier cycles
   task automatic duty_case(input int p, input int ca, input int cb);
      int hi_a, hi_b, ex_a, ex_b;
      wr(3'd0, W'(p), 1'b0);
      wr(3'd5, W'(2), 1'b0);
      wr(3'd3, W'(ca), 1'b0);
      wr(3'd4, W'(cb), 1'b0);
      idle(1, 1'b0);
      wr(3'd2, '0, 1'b0);                       // R9 preset from zero, up
      step(1'b0, 3'd0, '0, 1'b0, 1'b0, 1'b1, 1'b0);
      hi_a = 0; hi_b = 0;
      for (int k = 0; k < 4 * p; k++) begin
         if (out_a) hi_a++;
         if (out_b) hi_b++;
         idle(1, 1'b1);
      end
      ex_a = (ca > 0 && ca < p) ? 4 * ca : 4 * p;
      ex_b = (cb > 0 && cb < p) ? 4 * cb : 4 * p;
      chk(hi_a, ex_a, "R10 duty A");
      chk(hi_b, ex_b, "R10 duty B");
      step(1'b0, 3'd0, '0, 1'b0, 1'b1, 1'b0, 1'b0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      logic [W-1:0] held;
      m_cnt = 0; m_per = 0; m_ph = 0; m_up = 1'b1; m_trip = 1'b1; m_ctrl = 0;
      m_lvl = 2'b11;
      for (int i = 0; i < 2; i++) begin m_act[i] = 0; m_sh[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R11 reset state: tripped, outputs low
      chk(out_a, 0, "R11 reset out_a");
      chk(out_b, 0, "R11 reset out_b");
      chk(cnt_out, 0, "R1 reset count");
      chk(sync_out, 0, "R2 reset sync_out");

      // R10 / R7 sweep over small periods and every compare value
      for (int p = 1; p <= 6; p++)
         for (int c = 0; c <= p + 1; c++)
            duty_case(p, c, (p - c < 0) ? 0 : p - c);

      // R8 shadow: change cmpA mid-carrier while running
      wr(3'd0, W'(8), 1'b0);
      wr(3'd3, W'(3), 1'b0);
      idle(1, 1'b0);
      wr(3'd2, '0, 1'b0);
      step(1'b0, 3'd0, '0, 1'b0, 1'b0, 1'b1, 1'b0);
      idle(2, 1'b1);
      wr(3'd3, W'(5), 1'b1);   // R8 not active before the turning point
      idle(40, 1'b1);

      // R2 freeze
      held = cnt_out;
      idle(4, 1'b0);
      chk(cnt_out, held, "R2 frozen count");

      // R4 phase load with direction down, then clamp, then disabled
      wr(3'd0, W'(10), 1'b0);
      wr(3'd1, W'(7), 1'b0);
      wr(3'd5, W'(1), 1'b0);
      wr(3'd2, W'(3), 1'b0);
      step(1'b0, 3'd0, '0, 1'b1, 1'b0, 1'b0, 1'b1);
      chk(cnt_out, 7, "R4 phase loaded");
      idle(1, 1'b1);
      chk(cnt_out, 6, "R4 direction down after load");
      wr(3'd1, W'(15), 1'b1);
      step(1'b0, 3'd0, '0, 1'b1, 1'b0, 1'b0, 1'b1);
      chk(cnt_out, 10, "R4 phase clamped to period");
      idle(1, 1'b1);
      chk(cnt_out, 9, "R4 step after clamp");
      wr(3'd5, W'(0), 1'b1);
      held = cnt_out;
      step(1'b0, 3'd0, '0, 1'b1, 1'b0, 1'b0, 1'b1);
      chk(cnt_out, held - 1, "R4 sync ignored when disabled");

      // R5 load at zero wins over reversal, direction up
      wr(3'd5, W'(3), 1'b1);
      wr(3'd1, W'(4), 1'b1);
      for (int k = 0; k < 30 && cnt_out != 0; k++) idle(1, 1'b1);
      chk(cnt_out, 0, "R5 reached zero");
      step(1'b0, 3'd0, '0, 1'b1, 1'b0, 1'b0, 1'b1);
      chk(cnt_out, 4, "R5 load at zero");
      idle(1, 1'b1);
      chk(cnt_out, 5, "R5 up after load");

      // R3 pass-through select
      wr(3'd5, W'(4), 1'b1);
      run = 1'b1; sync_in = 1'b1; wr_en = 1'b0; #1;
      chk(sync_out, 1, "R3 pass-through");
      step(1'b0, 3'd0, '0, 1'b1, 1'b0, 1'b0, 1'b1);
      idle(25, 1'b1);

      // R9 counter write beats sync load
      wr(3'd5, W'(1), 1'b1);
      step(1'b1, 3'd2, W'(4), 1'b1, 1'b0, 1'b0, 1'b1);
      chk(cnt_out, 4, "R9 write wins over sync");

      // R11 trip force, force with clear, release
      step(1'b0, 3'd0, '0, 1'b1, 1'b0, 1'b1, 1'b0);
      step(1'b0, 3'd0, '0, 1'b1, 1'b1, 1'b0, 1'b0);
      chk(out_a, 0, "R11 forced low");
      step(1'b0, 3'd0, '0, 1'b1, 1'b1, 1'b1, 1'b0);
      chk(out_b, 0, "R11 force wins over clear");
      step(1'b0, 3'd0, '0, 1'b1, 1'b0, 1'b1, 1'b0);
      idle(30, 1'b1);

      // R1 period zero holds count at zero
      wr(3'd0, W'(0), 1'b1);
      idle(3, 1'b1);
      chk(cnt_out, 0, "R1 zero period holds");

      summary();
   end
endmodule